// File: doc/BRIEF.md
# Idle Insert/Remove Elastic Buffer

This block is a receive-side elastic FIFO that sits between a recovered receive clock and a local user clock. Words enter on the write side at the recovered-clock rate, each tagged by an idle flag. Words leave on the read side at the user-clock rate. The two clocks may differ slightly in either direction, so the buffer keeps its fill level inside a window bounded by a low and a high latency threshold. It corrects the fill level only at idle words: it discards incoming idles when the buffer is too full, and it repeats an idle at the output when the buffer is too empty.

Each side tracks the other side's pointer through Gray-coded pointers and a flop synchronizer. The write side computes its own view of the occupancy and drops an idle word instead of storing it when that view exceeds the high threshold. The read side holds off output until the buffer first fills to the low threshold. After that it presents one word per cycle. When its occupancy view is below the low threshold and the head word is an idle, it presents that idle again without advancing. Correction runs only while the correction enable is high and the sequence-drop control is low. Otherwise the block behaves as a plain asynchronous FIFO.

Top module: `idle_elastic_buf`

## Requirements
- R1: Every word written with wr_valid=1 and wr_idle=0 appears exactly once on rd_data with rd_valid=1 and rd_idle=0, in write order.
- R2: No idle is removed or inserted unless cc_en=1 and seq_drop=0. Otherwise rm_pulse and ins_pulse stay 0.
- R3: While correction is on, an idle word (wr_valid=1, wr_idle=1) is removed if the write-side occupancy exceeds MAX_LAT. Write-side occupancy is the count of stored words minus the synchronized read pointer. A removed word is not stored, the write pointer holds, and rm_pulse is high for one write-clock cycle.
- R4: While correction is on, if the read-side occupancy is nonzero and below MIN_LAT and the head word is an idle, that idle is presented without advancing the read pointer, and ins_pulse is high for that one read-clock cycle. Reading resumes once the occupancy reaches MIN_LAT.
- R5: Non-idle words are never removed or repeated. If the stream carries no idles, no correction happens, however far the occupancy drifts.
- R6: After reset, rd_valid, rd_idle, ins_pulse and rm_pulse are 0. Nothing is presented until the read-side occupancy first reaches MIN_LAT.
- R7: After that first fill, an empty buffer gives rd_valid=0 for those cycles. Output resumes as soon as a word is visible, without waiting for MIN_LAT again.
- R8: A repeated idle is presented with rd_valid=1 and rd_idle=1 in the same cycle that ins_pulse is 1.
- R9: rm_pulse is only raised for a write cycle in which wr_valid=1 and wr_idle=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered receive clock (write side) |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write side |
| wr_data | input | DATA_W | Incoming word |
| wr_valid | input | 1 | Incoming word present this cycle |
| wr_idle | input | 1 | 1 marks the incoming word as an idle |
| rd_clk | input | 1 | User clock (read side) |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read side |
| cc_en | input | 1 | Correction enable (active high) |
| seq_drop | input | 1 | Sequence-drop control; 1 disables idle correction |
| rd_data | output | DATA_W | Outgoing word |
| rd_idle | output | 1 | 1 marks the outgoing word as an idle |
| rd_valid | output | 1 | Outgoing word present; 0 while priming or empty |
| ins_pulse | output | 1 | One read-clock pulse per repeated idle |
| rm_pulse | output | 1 | One write-clock pulse per discarded idle |

## Verification
A written word is registered into the write pointer at the write edge. It crosses SYNC_STAGES read-clock flops and then the read output register, so it reaches rd_data about SYNC_STAGES+2 read cycles later. The bench waits 20 read cycles or more before it judges fill, drain and underflow results. It samples every output 1 ns after a rising edge, with inputs driven on falling edges. rm_pulse belongs to the write cycle right after the idle was captured, so the bench checks it in that cycle against the word still held on the write inputs. ins_pulse is checked in the same read cycle as the repeated word it marks. Rate-mismatch runs are judged after a drain period, through the total and order of delivered words and the presence or absence of correction pulses.

// File: rtl/eb_pkg.sv
`timescale 1ns/1ps
package eb_pkg;

    localparam int CODE_W = 32;

    function automatic logic [CODE_W-1:0] bin2gray(input logic [CODE_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [CODE_W-1:0] gray2bin(input logic [CODE_W-1:0] g);
        logic [CODE_W-1:0] b;
        b[CODE_W-1] = g[CODE_W-1];
        for (int i = CODE_W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/eb_gray_sync.sv
`timescale 1ns/1ps
module eb_gray_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    logic [W-1:0] chain_d [STAGES];
    logic [W-1:0] chain_q [STAGES];

    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb chain_d[g] = d_in;
        end else begin : g_next
            always_comb chain_d[g] = chain_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= chain_d[g];
        end
    end

    assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/eb_mem.sv
`timescale 1ns/1ps
module eb_mem #(
    parameter int ENT_W  = 17,
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ENT_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ENT_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ENT_W-1:0] store_q [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) store_q[waddr] <= wdata;
    end

    assign rdata = store_q[raddr];
endmodule

// File: rtl/eb_wr_ctrl.sv
`timescale 1ns/1ps
module eb_wr_ctrl #(
    parameter int ADDR_W  = 4,
    parameter int MAX_LAT = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_idle,
    input  logic              corr_on,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W:0]   wbin,
    output logic              rm_pulse
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] MAX_OCC = PTR_W'(MAX_LAT);
    localparam logic [PTR_W-1:0] ONE     = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0] bin;
        logic [PTR_W-1:0] gray;
        logic             rm;
    } wst_t;

    wst_t             st_d, st_q;
    logic [PTR_W-1:0] rbin_seen;
    logic [PTR_W-1:0] occ;
    logic             drop;

    always_comb begin
        rbin_seen = PTR_W'(eb_pkg::gray2bin(eb_pkg::CODE_W'(rgray_sync)));
        occ       = st_q.bin - rbin_seen;
        drop      = corr_on && wr_valid && wr_idle && (occ > MAX_OCC);
        we        = wr_valid && !drop;
        st_d      = st_q;
        st_d.rm   = drop;
        if (we) st_d.bin = st_q.bin + ONE;
        st_d.gray = PTR_W'(eb_pkg::bin2gray(eb_pkg::CODE_W'(st_d.bin)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waddr    = st_q.bin[ADDR_W-1:0];
    assign wgray    = st_q.gray;
    assign wbin     = st_q.bin;
    assign rm_pulse = st_q.rm;
endmodule

// File: rtl/eb_rd_ctrl.sv
`timescale 1ns/1ps
module eb_rd_ctrl #(
    parameter int ADDR_W  = 4,
    parameter int DATA_W  = 16,
    parameter int MIN_LAT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              corr_on,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] head_data,
    input  logic              head_idle,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [ADDR_W:0]   rbin,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_idle,
    output logic              rd_valid,
    output logic              ins_pulse
);
    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] MIN_OCC = PTR_W'(MIN_LAT);
    localparam logic [PTR_W-1:0] ONE     = PTR_W'(1);

    typedef struct packed {
        logic [PTR_W-1:0]  bin;
        logic [PTR_W-1:0]  gray;
        logic              primed;
        logic              valid;
        logic              idle;
        logic              ins;
        logic [DATA_W-1:0] data;
    } rst_t;

    rst_t             st_d, st_q;
    logic [PTR_W-1:0] wbin_seen;
    logic [PTR_W-1:0] occ;

    always_comb begin
        wbin_seen  = PTR_W'(eb_pkg::gray2bin(eb_pkg::CODE_W'(wgray_sync)));
        occ        = wbin_seen - st_q.bin;
        st_d       = st_q;
        st_d.valid = 1'b0;
        st_d.idle  = 1'b0;
        st_d.ins   = 1'b0;
        if (!st_q.primed && (occ >= MIN_OCC)) st_d.primed = 1'b1;
        if (st_q.primed && (occ != '0)) begin
            st_d.valid = 1'b1;
            st_d.data  = head_data;
            st_d.idle  = head_idle;
            if (corr_on && head_idle && (occ < MIN_OCC)) begin
                st_d.ins = 1'b1;
            end else begin
                st_d.bin = st_q.bin + ONE;
            end
        end
        st_d.gray = PTR_W'(eb_pkg::bin2gray(eb_pkg::CODE_W'(st_d.bin)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raddr     = st_q.bin[ADDR_W-1:0];
    assign rgray     = st_q.gray;
    assign rbin      = st_q.bin;
    assign rd_data   = st_q.data;
    assign rd_idle   = st_q.idle;
    assign rd_valid  = st_q.valid;
    assign ins_pulse = st_q.ins;
endmodule

// File: rtl/idle_elastic_buf.sv
`timescale 1ns/1ps
module idle_elastic_buf #(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 4,
    parameter int MIN_LAT     = 4,
    parameter int MAX_LAT     = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_valid,
    input  logic              wr_idle,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              cc_en,
    input  logic              seq_drop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_idle,
    output logic              rd_valid,
    output logic              ins_pulse,
    output logic              rm_pulse
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int ENT_W = DATA_W + 1;

    logic              corr_on;
    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PTR_W-1:0]  wgray, rgray, wgray_rs, rgray_ws;
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [ENT_W-1:0]  head;

    assign corr_on = cc_en && !seq_drop;

    eb_mem #(.ENT_W(ENT_W), .ADDR_W(ADDR_W)) u_mem (
        .wr_clk (wr_clk),
        .we     (we),
        .waddr  (waddr),
        .wdata  ({wr_idle, wr_data}),
        .raddr  (raddr),
        .rdata  (head)
    );

    eb_wr_ctrl #(.ADDR_W(ADDR_W), .MAX_LAT(MAX_LAT)) u_wr (
        .clk        (wr_clk),
        .rst_n      (wr_rst_n),
        .wr_valid   (wr_valid),
        .wr_idle    (wr_idle),
        .corr_on    (corr_on),
        .rgray_sync (rgray_ws),
        .we         (we),
        .waddr      (waddr),
        .wgray      (wgray),
        .wbin       (wr_ptr),
        .rm_pulse   (rm_pulse)
    );

    eb_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d_in  (wgray),
        .q_out (wgray_rs)
    );

    eb_gray_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d_in  (rgray),
        .q_out (rgray_ws)
    );

    eb_rd_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_LAT(MIN_LAT)) u_rd (
        .clk        (rd_clk),
        .rst_n      (rd_rst_n),
        .corr_on    (corr_on),
        .wgray_sync (wgray_rs),
        .head_data  (head[DATA_W-1:0]),
        .head_idle  (head[DATA_W]),
        .raddr      (raddr),
        .rgray      (rgray),
        .rbin       (rd_ptr),
        .rd_data    (rd_data),
        .rd_idle    (rd_idle),
        .rd_valid   (rd_valid),
        .ins_pulse  (ins_pulse)
    );
endmodule

// File: rtl/eb_chk.sv
`timescale 1ns/1ps
module eb_chk #(
    parameter int PTR_W = 5
) (
    input logic             wr_clk,
    input logic             wr_rst_n,
    input logic             rd_clk,
    input logic             rd_rst_n,
    input logic             cc_en,
    input logic             seq_drop,
    input logic             wr_valid,
    input logic             wr_idle,
    input logic             rm_pulse,
    input logic             ins_pulse,
    input logic             rd_valid,
    input logic             rd_idle,
    input logic [PTR_W-1:0] wr_ptr,
    input logic [PTR_W-1:0] rd_ptr
);
    // R1
    rd_advance_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_valid && !ins_pulse) |-> (rd_ptr == PTR_W'($past(rd_ptr) + PTR_W'(1))));

    // R2
    rm_gate_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        rm_pulse |-> $past(cc_en && !seq_drop));

    // R2
    ins_gate_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ins_pulse |-> $past(cc_en && !seq_drop));

    // R3
    rm_no_store_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        rm_pulse |-> $stable(wr_ptr));

    // R4
    ins_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ins_pulse |-> $stable(rd_ptr));

    // R8
    ins_is_idle_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        ins_pulse |-> (rd_valid && rd_idle));

    // R9
    rm_only_idle_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        rm_pulse |-> $past(wr_valid && wr_idle));
endmodule

bind idle_elastic_buf eb_chk #(.PTR_W(ADDR_W + 1)) u_chk (
    .wr_clk    (wr_clk),
    .wr_rst_n  (wr_rst_n),
    .rd_clk    (rd_clk),
    .rd_rst_n  (rd_rst_n),
    .cc_en     (cc_en),
    .seq_drop  (seq_drop),
    .wr_valid  (wr_valid),
    .wr_idle   (wr_idle),
    .rm_pulse  (rm_pulse),
    .ins_pulse (ins_pulse),
    .rd_valid  (rd_valid),
    .rd_idle   (rd_idle),
    .wr_ptr    (wr_ptr),
    .rd_ptr    (rd_ptr)
);

// File: tb/tb_idle_elastic_buf.sv
`timescale 1ns/1ps
module tb_idle_elastic_buf;
    localparam int DATA_W  = 16;
    localparam int MIN_LAT = 4;
    localparam int MAX_LAT = 10;
    localparam int RUN_LEN = 3000;

    typedef struct packed {
        logic [15:0] half_ps;
        logic        cc;
        logic        drop;
        logic [3:0]  idle_per;
        logic [1:0]  want;     // 0: no correction, 1: removals, 2: insertions
    } scen_t;

    localparam scen_t SCEN [6] = '{
        '{16'd2450, 1'b1, 1'b0, 4'd4, 2'd1},
        '{16'd2550, 1'b1, 1'b0, 4'd4, 2'd2},
        '{16'd2550, 1'b0, 1'b0, 4'd4, 2'd0},
        '{16'd2550, 1'b1, 1'b1, 4'd4, 2'd0},
        '{16'd2550, 1'b1, 1'b0, 4'd0, 2'd0},
        '{16'd2450, 1'b1, 1'b0, 4'd3, 2'd1}
    };

    logic              wr_clk = 1'b0, rd_clk = 1'b0;
    logic              wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              wr_valid = 1'b0, wr_idle = 1'b0;
    logic              cc_en = 1'b1, seq_drop = 1'b0;
    logic [DATA_W-1:0] rd_data;
    logic              rd_idle, rd_valid, ins_pulse, rm_pulse;

    realtime wr_half = 2.5;
    int checks = 0, fails = 0;
    int tx_seq = 0, exp_seq = 0, rx_cnt = 0, ins_cnt = 0, rm_cnt = 0;
    bit done = 1'b0;

    always #2.5 rd_clk = ~rd_clk;
    always #(wr_half) wr_clk = ~wr_clk;

    idle_elastic_buf #(.DATA_W(DATA_W), .ADDR_W(4), .MIN_LAT(MIN_LAT),
                       .MAX_LAT(MAX_LAT), .SYNC_STAGES(2)) dut (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_data(wr_data),
        .wr_valid(wr_valid), .wr_idle(wr_idle), .rd_clk(rd_clk),
        .rd_rst_n(rd_rst_n), .cc_en(cc_en), .seq_drop(seq_drop),
        .rd_data(rd_data), .rd_idle(rd_idle), .rd_valid(rd_valid),
        .ins_pulse(ins_pulse), .rm_pulse(rm_pulse)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // read-side monitor, 1 ns after each read edge
    always begin
        @(posedge rd_clk);
        #1;
        if (rd_rst_n) begin
            if (rd_valid && !rd_idle) begin
                // R1: order and single delivery
                chk(rd_data == DATA_W'(exp_seq), "R1", "delivered word",
                    int'(rd_data), exp_seq & 16'hFFFF);
                exp_seq++;
                rx_cnt++;
            end
            if (ins_pulse) ins_cnt++;
        end
    end

    // write-side monitor, 1 ns after each write edge
    always begin
        @(posedge wr_clk);
        #1;
        if (wr_rst_n && rm_pulse) begin
            rm_cnt++;
            // R9: removal only for a captured idle word
            chk(wr_valid && wr_idle, "R9", "removed word was idle",
                int'({wr_valid, wr_idle}), 3);
        end
    end

    task automatic do_reset();
        @(negedge rd_clk);
        wr_valid = 1'b0;
        wr_rst_n = 1'b0;
        rd_rst_n = 1'b0;
        repeat (4) @(posedge rd_clk);
        tx_seq = 0; exp_seq = 0; rx_cnt = 0; ins_cnt = 0; rm_cnt = 0;
        @(negedge rd_clk);
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
    endtask

    task automatic send(input bit idle);
        @(negedge wr_clk);
        wr_valid = 1'b1;
        wr_idle  = idle;
        wr_data  = idle ? 16'hB5B5 : DATA_W'(tx_seq);
        if (!idle) tx_seq++;
    endtask

    task automatic stop_wr();
        @(negedge wr_clk);
        wr_valid = 1'b0;
        wr_idle  = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge rd_clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int held;
        // R6: reset state
        do_reset();
        @(posedge rd_clk); #1;
        chk(!rd_valid, "R6", "rd_valid after reset", int'(rd_valid), 0);
        chk(!rd_idle, "R6", "rd_idle after reset", int'(rd_idle), 0);
        chk(!ins_pulse, "R6", "ins_pulse after reset", int'(ins_pulse), 0);
        chk(!rm_pulse, "R6", "rm_pulse after reset", int'(rm_pulse), 0);

        // table of rate-mismatch scenarios
        for (int s = 0; s < 6; s++) begin
            wr_half  = real'(SCEN[s].half_ps) / 1000.0;
            cc_en    = SCEN[s].cc;
            seq_drop = SCEN[s].drop;
            do_reset();
            for (int i = 0; i < RUN_LEN; i++) begin
                send(SCEN[s].idle_per != 0 &&
                     (i % int'(SCEN[s].idle_per)) == int'(SCEN[s].idle_per) - 1);
            end
            for (int i = 0; i < MAX_LAT + 2; i++) send(1'b0);
            stop_wr();
            repeat (80) @(posedge rd_clk);
            #1;
            chk(rx_cnt == tx_seq, "R1", "words delivered", rx_cnt, tx_seq);
            if (SCEN[s].want == 2'd1)
                chk(rm_cnt > 0, "R3", "removals with fast writer", rm_cnt, 1);
            else if (SCEN[s].want == 2'd2)
                chk(ins_cnt > 0, "R4", "insertions with slow writer", ins_cnt, 1);
            else if (SCEN[s].idle_per == 0)
                chk(rm_cnt == 0 && ins_cnt == 0, "R5", "corrections without idles",
                    rm_cnt + ins_cnt, 0);
            else
                chk(rm_cnt == 0 && ins_cnt == 0, "R2", "corrections while disabled",
                    rm_cnt + ins_cnt, 0);
        end

        // directed: priming, underflow and a repeated idle at equal rates
        wr_half  = 2.5;
        cc_en    = 1'b1;
        seq_drop = 1'b0;
        do_reset();
        for (int i = 0; i < MIN_LAT - 1; i++) send(1'b0);
        stop_wr();
        repeat (20) @(posedge rd_clk); #1;
        chk(rx_cnt == 0, "R6", "no output below first fill", rx_cnt, 0);
        chk(!rd_valid, "R6", "rd_valid below first fill", int'(rd_valid), 0);
        send(1'b0);
        stop_wr();
        repeat (20) @(posedge rd_clk); #1;
        chk(rx_cnt == MIN_LAT, "R6", "words after first fill", rx_cnt, MIN_LAT);
        chk(!rd_valid, "R7", "rd_valid when empty", int'(rd_valid), 0);
        send(1'b0);
        stop_wr();
        repeat (20) @(posedge rd_clk); #1;
        chk(rx_cnt == MIN_LAT + 1, "R7", "single word without refill", rx_cnt, MIN_LAT + 1);
        send(1'b1);
        stop_wr();
        repeat (20) @(posedge rd_clk); #1;
        chk(rd_valid && rd_idle, "R8", "repeated idle shown", int'({rd_valid, rd_idle}), 3);
        chk(ins_pulse, "R4", "ins_pulse while low", int'(ins_pulse), 1);
        chk(ins_cnt >= 15, "R4", "idle repeated each cycle", ins_cnt, 15);
        for (int i = 0; i < MIN_LAT; i++) send(1'b0);
        stop_wr();
        repeat (20) @(posedge rd_clk); #1;
        chk(rx_cnt == 2 * MIN_LAT + 1, "R4", "data after repeated idle", rx_cnt, 2 * MIN_LAT + 1);
        held = ins_cnt;
        repeat (10) @(posedge rd_clk); #1;
        chk(ins_cnt == held, "R4", "insertion stopped", ins_cnt, held);
        chk(rm_cnt == 0, "R5", "no removal below MAX_LAT", rm_cnt, 0);

        finish_run();
    end
endmodule